// File: doc/BRIEF.md
# Keyboard/Auxiliary Output Buffer Arbiter

This block sits between two byte sources of a PC-style input controller, a keyboard channel and an auxiliary (pointing device) channel, and the host-visible side of the controller. Each channel raises a pending flag while it holds a byte for the host. From the two flags and the controller mode byte, the block produces the buffer-full flags for the status register, a copy of those flags for the output port, and two level interrupt requests.

It also steers host data reads. A read returns the byte of the channel the status register currently names, and sends a one-cycle pop strobe to that channel only. When both channels are pending the keyboard channel is always served first. The auxiliary channel is reported, interrupts and is read only when it is the sole pending source.

All flags and interrupt lines are recomputed from the present inputs and registered once. A change on a pending flag or a mode bit therefore shows one clock later.

Top module: `obuf_arbiter`

## Requirements
- R1: During and right after reset, every flag output, both interrupt lines and both pop strobes are 0.
- R2: One cycle after a clock edge that samples either pending flag high, `stat_full` (status bit 0) and `port_full` (output port bit 4) are 1. They are 0 one cycle after both flags are sampled low.
- R3: `stat_aux_full` (status bit 5) and `port_aux_full` (output port bit 5) are 1 one cycle after a sample in which the auxiliary flag is high and the keyboard flag is low. Otherwise they are 0.
- R4: `aux_irq` is 1 one cycle after a sample in which only the auxiliary flag is high and mode bit 1 is 1.
- R5: `kbd_irq` is 1 one cycle after a sample in which the keyboard flag is high, mode bit 0 is 1 and mode bit 4 is 0. The auxiliary flag has no effect on it.
- R6: `rd_data` equals `aux_byte` while `stat_aux_full` is 1, and equals `kbd_byte` otherwise, with no pipeline delay on the byte itself.
- R7: With `rd_en` high, exactly one pop strobe is high in the same cycle: `aux_pop` when `stat_aux_full` is 1, otherwise `kbd_pop`. With `rd_en` low, neither strobe is high.
- R8: Both interrupt lines are 0 one cycle after both pending flags are sampled low, for any mode value.
- R9: Mode bits 2, 3, 5, 6 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_pend | input | 1 | Keyboard channel holds a byte |
| aux_pend | input | 1 | Auxiliary channel holds a byte |
| mode | input | 8 | Controller mode byte (bit 0 keyboard IRQ enable, bit 1 aux IRQ enable, bit 4 keyboard disable) |
| kbd_byte | input | 8 | Head byte of the keyboard channel |
| aux_byte | input | 8 | Head byte of the auxiliary channel |
| rd_en | input | 1 | Host data-port read strobe |
| rd_data | output | 8 | Byte returned to the host |
| kbd_pop | output | 1 | Consume strobe to the keyboard channel |
| aux_pop | output | 1 | Consume strobe to the auxiliary channel |
| stat_full | output | 1 | Status bit 0, any byte waiting |
| stat_aux_full | output | 1 | Status bit 5, waiting byte is auxiliary |
| port_full | output | 1 | Output port bit 4 |
| port_aux_full | output | 1 | Output port bit 5 |
| kbd_irq | output | 1 | Keyboard interrupt request level |
| aux_irq | output | 1 | Auxiliary interrupt request level |

## Verification
The assertions assume that the pending flags, the mode byte and `rd_en` are synchronous to `clk` and free of unknown values after reset. They also assume that each channel's pending flag is the only thing that tells whether that channel has data. The bench changes every input on the falling edge and holds it across the next rising edge. It reads registered outputs one step after that edge, and it raises `rd_en` only between edges, so each read lines up with one settled selection.

// File: rtl/obuf_arb_pkg.sv
package obuf_arb_pkg;

  // Which channel the host side is currently pointed at.
  typedef enum logic {
    SRC_KBD = 1'b0,
    SRC_AUX = 1'b1
  } src_sel_e;

  // Any channel holding data.
  function automatic logic any_waiting(input logic k, input logic a);
    return k | a;
  endfunction

  // The auxiliary channel is served only when the keyboard has nothing.
  function automatic logic aux_alone(input logic k, input logic a);
    return a & ~k;
  endfunction

endpackage

// File: rtl/obuf_src_decode.sv
module obuf_src_decode
  import obuf_arb_pkg::*;
(
  input  logic     kbd_pend,
  input  logic     aux_pend,
  output logic     any_pend,
  output src_sel_e src
);

  always_comb begin
    any_pend = any_waiting(kbd_pend, aux_pend);
    src      = aux_alone(kbd_pend, aux_pend) ? SRC_AUX : SRC_KBD;
  end

endmodule

// File: rtl/obuf_irq_gate.sv
module obuf_irq_gate
  import obuf_arb_pkg::*;
#(
  parameter int MODE_W       = 8,
  parameter int KBD_IE_BIT   = 0,
  parameter int AUX_IE_BIT   = 1,
  parameter int KBD_DIS_BIT  = 4,
  parameter bit HONOR_KBD_DIS = 1'b1
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              kbd_pend,
  input  src_sel_e          src,
  output logic              kbd_req,
  output logic              aux_req
);

  logic kbd_blocked;
  logic mode_unused;

  generate
    if (HONOR_KBD_DIS) begin : g_dis
      assign kbd_blocked = mode[KBD_DIS_BIT];
    end else begin : g_nodis
      assign kbd_blocked = 1'b0;
    end
  endgenerate

  assign mode_unused = ^mode;

  always_comb begin
    kbd_req = kbd_pend & mode[KBD_IE_BIT] & ~kbd_blocked;
    aux_req = (src == SRC_AUX) & mode[AUX_IE_BIT];
  end

endmodule

// File: rtl/obuf_read_mux.sv
module obuf_read_mux
  import obuf_arb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  src_sel_e          src_q,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] kbd_byte,
  input  logic [DATA_W-1:0] aux_byte,
  output logic [DATA_W-1:0] rd_data,
  output logic              kbd_pop,
  output logic              aux_pop
);

  always_comb begin
    rd_data = (src_q == SRC_AUX) ? aux_byte : kbd_byte;
    kbd_pop = rd_en & (src_q == SRC_KBD);
    aux_pop = rd_en & (src_q == SRC_AUX);
  end

endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
  import obuf_arb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MODE_W      = 8,
  parameter int KBD_IE_BIT  = 0,
  parameter int AUX_IE_BIT  = 1,
  parameter int KBD_DIS_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_pend,
  input  logic              aux_pend,
  input  logic [MODE_W-1:0] mode,
  input  logic [DATA_W-1:0] kbd_byte,
  input  logic [DATA_W-1:0] aux_byte,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              kbd_pop,
  output logic              aux_pop,
  output logic              stat_full,
  output logic              stat_aux_full,
  output logic              port_full,
  output logic              port_aux_full,
  output logic              kbd_irq,
  output logic              aux_irq
);

  // Next-state events, named for the assertions.
  logic     any_d;
  src_sel_e src_d;
  logic     kbd_req_d;
  logic     aux_req_d;

  // Registered state.
  logic     full_q;
  src_sel_e src_q;
  logic     kbd_irq_q;
  logic     aux_irq_q;

  obuf_src_decode u_dec (
    .kbd_pend (kbd_pend),
    .aux_pend (aux_pend),
    .any_pend (any_d),
    .src      (src_d)
  );

  obuf_irq_gate #(
    .MODE_W        (MODE_W),
    .KBD_IE_BIT    (KBD_IE_BIT),
    .AUX_IE_BIT    (AUX_IE_BIT),
    .KBD_DIS_BIT   (KBD_DIS_BIT),
    .HONOR_KBD_DIS (1'b1)
  ) u_irq (
    .mode     (mode),
    .kbd_pend (kbd_pend),
    .src      (src_d),
    .kbd_req  (kbd_req_d),
    .aux_req  (aux_req_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      src_q     <= SRC_KBD;
      kbd_irq_q <= 1'b0;
      aux_irq_q <= 1'b0;
    end else begin
      full_q    <= any_d;
      src_q     <= src_d;
      kbd_irq_q <= kbd_req_d;
      aux_irq_q <= aux_req_d;
    end
  end

  obuf_read_mux #(
    .DATA_W (DATA_W)
  ) u_rd (
    .src_q    (src_q),
    .rd_en    (rd_en),
    .kbd_byte (kbd_byte),
    .aux_byte (aux_byte),
    .rd_data  (rd_data),
    .kbd_pop  (kbd_pop),
    .aux_pop  (aux_pop)
  );

  assign stat_full     = full_q;
  assign port_full     = full_q;
  assign stat_aux_full = (src_q == SRC_AUX);
  assign port_aux_full = (src_q == SRC_AUX);
  assign kbd_irq       = kbd_irq_q;
  assign aux_irq       = aux_irq_q;

  // R2
  full_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_full == $past(kbd_pend | aux_pend)));

  // R3
  aux_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stat_aux_full == ($past(aux_pend) && !$past(kbd_pend))));

  // R4
  aux_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> (stat_aux_full && stat_full));

  // R5
  kbd_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> (stat_full && !stat_aux_full));

  // R7
  pop_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ($countones({kbd_pop, aux_pop}) == 1));

  // R7
  pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> !(kbd_pop || aux_pop));

  // R8
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_full |-> !(kbd_irq || aux_irq));

endmodule

// File: tb/sim_obuf_arbiter.sv
`timescale 1ns/1ps
module sim_obuf_arbiter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_pend = 1'b0;
  logic       aux_pend = 1'b0;
  logic [7:0] mode = 8'h00;
  logic [7:0] kbd_byte = 8'h00;
  logic [7:0] aux_byte = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       kbd_pop, aux_pop;
  logic       stat_full, stat_aux_full, port_full, port_aux_full;
  logic       kbd_irq, aux_irq;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  obuf_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .kbd_pend(kbd_pend), .aux_pend(aux_pend),
    .mode(mode), .kbd_byte(kbd_byte), .aux_byte(aux_byte), .rd_en(rd_en),
    .rd_data(rd_data), .kbd_pop(kbd_pop), .aux_pop(aux_pop),
    .stat_full(stat_full), .stat_aux_full(stat_aux_full),
    .port_full(port_full), .port_aux_full(port_aux_full),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, sample just after the rising edge.
  task automatic apply(input logic k, input logic a, input logic [7:0] m);
    @(negedge clk);
    kbd_pend = k;
    aux_pend = a;
    mode = m;
    @(posedge clk);
    #1;
  endtask

  // Expectations written from the requirement text.
  task automatic verify_flags(input string tag, input logic k, input logic a, input logic [7:0] m);
    logic e_full, e_aux, e_ki, e_ai;
    e_full = (k === 1'b1) || (a === 1'b1);
    e_aux  = (a === 1'b1) && (k === 1'b0);
    e_ai   = e_aux && m[1];
    e_ki   = k && m[0] && !m[4];
    chk({tag, " R2 stat_full"}, {7'd0, stat_full}, {7'd0, e_full});
    chk({tag, " R2 port_full"}, {7'd0, port_full}, {7'd0, e_full});
    chk({tag, " R3 stat_aux_full"}, {7'd0, stat_aux_full}, {7'd0, e_aux});
    chk({tag, " R3 port_aux_full"}, {7'd0, port_aux_full}, {7'd0, e_aux});
    chk({tag, " R4 aux_irq"}, {7'd0, aux_irq}, {7'd0, e_ai});
    chk({tag, " R5 kbd_irq"}, {7'd0, kbd_irq}, {7'd0, e_ki});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    kbd_pend = 1'b1; aux_pend = 1'b1; mode = 8'hFF;
    #22;
    chk("R1 stat_full", {7'd0, stat_full}, 8'd0);
    chk("R1 stat_aux_full", {7'd0, stat_aux_full}, 8'd0);
    chk("R1 irqs", {6'd0, kbd_irq, aux_irq}, 8'd0);
    chk("R1 pops", {6'd0, kbd_pop, aux_pop}, 8'd0);
    @(negedge clk);
    kbd_pend = 1'b0; aux_pend = 1'b0; mode = 8'h03;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 after release", {4'd0, stat_full, port_full, kbd_irq, aux_irq}, 8'd0);
  endtask

  task automatic t_sources();
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] mv;
        mv = {3'b000, (m == 3) ? 1'b1 : 1'b0, 2'b00, m[1:0] | {1'b0, (m == 3) ? 1'b1 : 1'b0}};
        apply(s[0], s[1], mv);
        verify_flags("src", s[0], s[1], mv);
      end
    end
  endtask

  task automatic t_quiet();
    apply(1'b1, 1'b0, 8'h03);
    apply(1'b0, 1'b0, 8'h03);
    chk("R8 irqs low after idle", {6'd0, kbd_irq, aux_irq}, 8'd0);
    apply(1'b0, 1'b0, 8'hFF);
    chk("R8 irqs low all mode", {6'd0, kbd_irq, aux_irq}, 8'd0);
  endtask

  task automatic t_mode_latency();
    apply(1'b1, 1'b0, 8'h00);
    @(negedge clk); mode = 8'h01;
    #2;
    chk("R5 no same-cycle effect", {7'd0, kbd_irq}, 8'd0);
    @(posedge clk); #1;
    chk("R5 next-cycle effect", {7'd0, kbd_irq}, 8'd1);
    apply(1'b1, 1'b0, 8'h11);
    chk("R5 disable bit gates", {7'd0, kbd_irq}, 8'd0);
    apply(1'b1, 1'b1, 8'h03);
    chk("R5 aux ignored for kbd irq", {7'd0, kbd_irq}, 8'd1);
    chk("R4 aux irq held off by kbd", {7'd0, aux_irq}, 8'd0);
  endtask

  task automatic t_unused_bits();
    logic [7:0] pats [4];
    pats[0] = 8'h04; pats[1] = 8'h08; pats[2] = 8'h20; pats[3] = 8'hEC;
    foreach (pats[i]) begin
      apply(1'b0, 1'b1, pats[i] | 8'h03);
      verify_flags("R9 aux", 1'b0, 1'b1, 8'h03);
      apply(1'b1, 1'b0, pats[i] | 8'h03);
      verify_flags("R9 kbd", 1'b1, 1'b0, 8'h03);
    end
  endtask

  task automatic t_read();
    kbd_byte = 8'h5A; aux_byte = 8'hC3;
    apply(1'b0, 1'b1, 8'h03);
    #1;
    chk("R6 aux byte", rd_data, 8'hC3);
    chk("R7 idle pops", {6'd0, kbd_pop, aux_pop}, 8'd0);
    rd_en = 1'b1; #1;
    chk("R7 aux pop", {6'd0, kbd_pop, aux_pop}, 8'd1);
    rd_en = 1'b0;
    aux_byte = 8'h3C; #1;
    chk("R6 byte not delayed", rd_data, 8'h3C);
    apply(1'b1, 1'b1, 8'h03);
    #1;
    chk("R6 kbd wins", rd_data, 8'h5A);
    rd_en = 1'b1; #1;
    chk("R7 kbd pop", {6'd0, kbd_pop, aux_pop}, 8'd2);
    rd_en = 1'b0;
    apply(1'b0, 1'b0, 8'h03);
    #1;
    chk("R6 none pending reads kbd", rd_data, 8'h5A);
    rd_en = 1'b1; #1;
    chk("R7 idle read pops kbd", {6'd0, kbd_pop, aux_pop}, 8'd2);
    rd_en = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_sources();
        t_quiet();
        t_mode_latency();
        t_unused_bits();
        t_read();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule